// File: doc/BRIEF.md
# Upset-Correcting Encoded State Sequencer

This block is a small modulo-N step sequencer whose state register never holds a bare state index. It holds a single-error-correcting Hamming code word instead. Every cycle the stored word is decoded and its syndrome is formed. A nonzero syndrome marks one flipped bit, and that bit is inverted before anything downstream uses the state. The next state is computed from the repaired index and encoded afresh before it is written back. A single upset in any stored bit therefore leaves the output sequence exactly as it would have been without the upset, and a one-cycle flag reports that a repair happened.

The state count is a parameter. The index width is derived from it, and the number of check bits r is the smallest value with 2^r >= m + r + 1, where m is the index width. The check-bit overhead therefore grows only with the logarithm of the machine size. The smallest configuration is a two-state toggle: one index bit protected by two check bits. A fault-injection mask lets a bench or a fault campaign flip any chosen bit of the stored word as it is written.

Top module: `seu_fix_fsm`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block loads the encoding of state 0. After that edge `state_o` is 0, `corr_o` is 0, and `last_o` is 0 whenever `NUM_STATES` is greater than 1.
- R2: With `clr_i` low and `adv_i` high, each rising edge moves `state_o` up by one. From `NUM_STATES-1` it wraps to 0.
- R3: With `clr_i` and `adv_i` both low, `state_o` keeps its value across the edge.
- R4: With `clr_i` high, the edge returns `state_o` to 0 whatever the value of `adv_i`.
- R5: `last_o` is high exactly while `state_o` equals `NUM_STATES-1`.
- R6: Bit i of `flip_i` inverts bit i of the code word stored at that edge. Bit i holds Hamming position i+1. Check bits sit at the power-of-two positions, and index bits fill the remaining positions in ascending order. Any single inverted bit, whether index or check, leaves `state_o` and `last_o` in the following cycle equal to the values without the flip.
- R7: `corr_o` is high during the cycle after an edge at which `flip_i` had exactly one bit set.
- R8: A repaired word does not persist. After an edge with `flip_i` all zero, `corr_o` is low and the sequence continues from the correct state.
- R9: During reset `flip_i` and `adv_i` have no effect. The state loaded is clean state 0 and `corr_o` stays low.
- R10: With `NUM_STATES = 2` the block is a toggle with a three-bit word. Any single flip in that word leaves the toggle sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| adv_i | input | 1 | Step to the next state |
| clr_i | input | 1 | Return to state 0; takes priority over `adv_i` |
| flip_i | input | WORD_W | Fault-injection mask XORed into the word being stored |
| state_o | output | STATE_W | Corrected current state index |
| last_o | output | 1 | High in the final state of the cycle |
| corr_o | output | 1 | A single-bit repair was made this cycle |

## Verification
A wrong internal word appears at `state_o` in the same cycle it is stored: if the decoder picked the wrong bit or missed one, the index seen at the port departs from the unprotected reference right after the injecting edge. A repair that leaked into the register would show one cycle later, either as a wrong step or as `corr_o` staying high with no new flip. The bench therefore compares each cycle against a plain modulo counter model. It injects into every bit position in every state of both the five-state and the two-state configurations.

// File: rtl/seu_fix_pkg.sv
`timescale 1ns/1ps
package seu_fix_pkg;

    // Smallest r with 2^r >= m + r + 1
    function automatic int unsigned check_count(input int unsigned m);
        int unsigned r;
        r = 1;
        while ((1 << r) < (m + r + 1)) r++;
        return r;
    endfunction

    // Width of a state index for n states (at least one bit)
    function automatic int unsigned index_width(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    function automatic bit is_pow2(input int unsigned p);
        return (p != 0) && ((p & (p - 1)) == 0);
    endfunction

    typedef enum logic [1:0] {
        CMD_HOLD  = 2'd0,
        CMD_STEP  = 2'd1,
        CMD_CLEAR = 2'd2
    } seq_cmd_e;

endpackage

// File: rtl/sec_encoder.sv
`timescale 1ns/1ps
module sec_encoder
    import seu_fix_pkg::*;
#(
    parameter int M = 3,
    parameter int R = 3,
    parameter int N = 6
) (
    input  logic [M-1:0] data_i,
    output logic [N-1:0] word_o
);

    always_comb begin
        logic [N-1:0] w;
        logic         par;
        int           k;
        w = '0;
        k = 0;
        // index bits into the non-power-of-two positions, ascending
        for (int p = 1; p <= N; p++) begin
            if (!is_pow2(p)) begin
                w[p-1] = data_i[k];
                k++;
            end
        end
        // check bit at position 2^j covers positions with bit j set
        for (int j = 0; j < R; j++) begin
            par = 1'b0;
            for (int p = 1; p <= N; p++) begin
                if (((p >> j) & 1) == 1 && !is_pow2(p)) par ^= w[p-1];
            end
            w[(1 << j) - 1] = par;
        end
        word_o = w;
    end

endmodule

// File: rtl/sec_decoder.sv
`timescale 1ns/1ps
module sec_decoder
    import seu_fix_pkg::*;
#(
    parameter int M = 3,
    parameter int R = 3,
    parameter int N = 6
) (
    input  logic [N-1:0] word_i,
    output logic [M-1:0] data_o,
    output logic         hit_o
);

    logic [R-1:0] syn;
    logic [N-1:0] fixed;

    always_comb begin
        syn = '0;
        for (int j = 0; j < R; j++) begin
            for (int p = 1; p <= N; p++) begin
                if (((p >> j) & 1) == 1) syn[j] = syn[j] ^ word_i[p-1];
            end
        end
    end

    always_comb begin
        fixed = word_i;
        for (int p = 1; p <= N; p++) begin
            if (syn == R'(p)) fixed[p-1] = ~word_i[p-1];
        end
    end

    always_comb begin
        int k;
        data_o = '0;
        k = 0;
        for (int p = 1; p <= N; p++) begin
            if (!is_pow2(p)) begin
                data_o[k] = fixed[p-1];
                k++;
            end
        end
    end

    assign hit_o = (syn != '0);

endmodule

// File: rtl/seq_next.sv
`timescale 1ns/1ps
module seq_next
    import seu_fix_pkg::*;
#(
    parameter int NS = 5,
    parameter int M  = 3
) (
    input  logic [M-1:0] state_i,
    input  logic         adv_i,
    input  logic         clr_i,
    output logic [M-1:0] state_o
);

    localparam logic [M-1:0] LAST = M'(NS - 1);

    seq_cmd_e cmd;

    always_comb begin
        if (clr_i)      cmd = CMD_CLEAR;
        else if (adv_i) cmd = CMD_STEP;
        else            cmd = CMD_HOLD;
    end

    always_comb begin
        unique case (cmd)
            CMD_CLEAR: state_o = '0;
            CMD_STEP:  state_o = (state_i >= LAST) ? '0 : state_i + 1'b1;
            default:   state_o = state_i;
        endcase
    end

endmodule

// File: rtl/seu_fix_fsm.sv
`timescale 1ns/1ps
module seu_fix_fsm
    import seu_fix_pkg::*;
#(
    parameter  int NUM_STATES = 5,
    localparam int STATE_W    = index_width(NUM_STATES),
    localparam int CHECK_W    = check_count(STATE_W),
    localparam int WORD_W     = STATE_W + CHECK_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               adv_i,
    input  logic               clr_i,
    input  logic [WORD_W-1:0]  flip_i,
    output logic [STATE_W-1:0] state_o,
    output logic               last_o,
    output logic               corr_o
);

    localparam logic [STATE_W-1:0] LAST = STATE_W'(NUM_STATES - 1);

    logic [WORD_W-1:0]  word_q;
    logic [WORD_W-1:0]  nxt_word;
    logic [STATE_W-1:0] cur_state;
    logic [STATE_W-1:0] nxt_state;
    logic               hit;

    sec_decoder #(.M(STATE_W), .R(CHECK_W), .N(WORD_W)) i_dec (
        .word_i (word_q),
        .data_o (cur_state),
        .hit_o  (hit)
    );

    seq_next #(.NS(NUM_STATES), .M(STATE_W)) i_next (
        .state_i (cur_state),
        .adv_i   (adv_i),
        .clr_i   (clr_i),
        .state_o (nxt_state)
    );

    sec_encoder #(.M(STATE_W), .R(CHECK_W), .N(WORD_W)) i_enc (
        .data_i (nxt_state),
        .word_o (nxt_word)
    );

    // State 0 encodes to the all-zero word
    always_ff @(posedge clk) begin
        if (rst) word_q <= '0;
        else     word_q <= nxt_word ^ flip_i;
    end

    assign state_o = cur_state;
    assign last_o  = (cur_state == LAST);
    assign corr_o  = hit;

endmodule

// File: rtl/seu_fix_fsm_chk.sv
`timescale 1ns/1ps
module seu_fix_fsm_chk
    import seu_fix_pkg::*;
#(
    parameter  int NUM_STATES = 5,
    localparam int STATE_W    = index_width(NUM_STATES),
    localparam int CHECK_W    = check_count(STATE_W),
    localparam int WORD_W     = STATE_W + CHECK_W
) (
    input logic               clk,
    input logic               rst,
    input logic               adv_i,
    input logic               clr_i,
    input logic [WORD_W-1:0]  flip_i,
    input logic [STATE_W-1:0] state_o,
    input logic               last_o,
    input logic               corr_o
);

    localparam logic [STATE_W-1:0] LAST = STATE_W'(NUM_STATES - 1);

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (state_o == '0) && !corr_o); // R1

    AST_STEP_WRAP: assert property (@(posedge clk) disable iff (rst)
        adv_i && !clr_i && $onehot0(flip_i) |=>
        state_o == (($past(state_o) >= LAST) ? '0 : $past(state_o) + 1'b1)); // R2

    AST_HOLD_STATE: assert property (@(posedge clk) disable iff (rst)
        !adv_i && !clr_i && $onehot0(flip_i) |=> $stable(state_o)); // R3

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clr_i && $onehot0(flip_i) |=> state_o == '0); // R4

    AST_FLAG_ON_FLIP: assert property (@(posedge clk) disable iff (rst)
        $onehot(flip_i) |=> corr_o); // R7

    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (rst)
        flip_i == '0 |=> !corr_o); // R8

endmodule

bind seu_fix_fsm seu_fix_fsm_chk #(.NUM_STATES(NUM_STATES)) i_chk (.*);

// File: tb/test_seu_fix_fsm.sv
`timescale 1ns/1ps
module test_seu_fix_fsm;

    localparam int A_NS = 5;
    localparam int A_W  = 6;   // 3 index bits + 3 check bits
    localparam int B_NS = 2;
    localparam int B_W  = 3;   // 1 index bit + 2 check bits

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;      // 250 MHz

    logic           a_adv = 0, a_clr = 0;
    logic [A_W-1:0] a_flip = '0;
    logic [2:0]     a_state;
    logic           a_last, a_corr;

    logic           b_adv = 0, b_clr = 0;
    logic [B_W-1:0] b_flip = '0;
    logic [0:0]     b_state;
    logic           b_last, b_corr;

    int total = 0;
    int bad   = 0;
    int ref_a = 0;
    int ref_b = 0;

    seu_fix_fsm #(.NUM_STATES(A_NS)) i_seu_fix_fsm (
        .clk(clk), .rst(rst), .adv_i(a_adv), .clr_i(a_clr), .flip_i(a_flip),
        .state_o(a_state), .last_o(a_last), .corr_o(a_corr)
    );

    seu_fix_fsm #(.NUM_STATES(B_NS)) i_seu_fix_fsm_two (
        .clk(clk), .rst(rst), .adv_i(b_adv), .clr_i(b_clr), .flip_i(b_flip),
        .state_o(b_state), .last_o(b_last), .corr_o(b_corr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int model(input int s, input bit adv, input bit clr, input int ns);
        if (clr) return 0;
        if (adv) return (s >= ns - 1) ? 0 : s + 1;
        return s;
    endfunction

    task automatic step_a(input bit adv, input bit clr, input logic [A_W-1:0] flip, input string req);
        @(negedge clk);
        a_adv = adv; a_clr = clr; a_flip = flip;
        @(posedge clk);
        #1;
        ref_a = model(ref_a, adv, clr, A_NS);
        chk(a_state == 3'(ref_a), req, a_state, ref_a);
        chk(a_last == (ref_a == A_NS - 1), "R5", a_last, ref_a == A_NS - 1);
        chk(a_corr == (flip != '0), (flip != '0) ? "R7" : "R8", a_corr, flip != '0);
    endtask

    task automatic step_b(input bit adv, input bit clr, input logic [B_W-1:0] flip, input string req);
        @(negedge clk);
        b_adv = adv; b_clr = clr; b_flip = flip;
        @(posedge clk);
        #1;
        ref_b = model(ref_b, adv, clr, B_NS);
        chk(b_state == 1'(ref_b), req, b_state, ref_b);
        chk(b_last == (ref_b == B_NS - 1), "R10", b_last, ref_b == B_NS - 1);
        chk(b_corr == (flip != '0), "R10", b_corr, flip != '0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst = 1; a_adv = 1; a_flip = 6'b000100; b_adv = 1; b_flip = 3'b010;
        repeat (3) @(posedge clk);
        #1;
        chk(a_state == 0, "R1", a_state, 0);
        chk(a_last == 0, "R1", a_last, 0);
        chk(a_corr == 0, "R9", a_corr, 0);
        chk(b_state == 0, "R1", b_state, 0);
        chk(b_corr == 0, "R9", b_corr, 0);
        @(negedge clk);
        rst = 0; a_adv = 0; a_flip = '0; b_adv = 0; b_flip = '0;
        ref_a = 0; ref_b = 0;
        @(posedge clk);
        #1;
        chk(a_state == 0 && a_corr == 0, "R9", a_state, 0);
    endtask

    task automatic t_count;
        for (int i = 0; i < 12; i++) step_a(1, 0, '0, "R2");
    endtask

    task automatic t_hold;
        step_a(1, 0, '0, "R2");
        for (int i = 0; i < 4; i++) step_a(0, 0, '0, "R3");
    endtask

    task automatic t_clear;
        step_a(1, 0, '0, "R2");
        step_a(1, 1, '0, "R4");
        step_a(0, 0, '0, "R3");
        step_a(1, 0, '0, "R2");
        step_a(0, 1, '0, "R4");
    endtask

    task automatic t_inject_a;
        for (int s = 0; s < A_NS; s++) begin
            for (int b = 0; b < A_W; b++) begin
                step_a(0, 1, '0, "R4");
                for (int k = 0; k < s; k++) step_a(1, 0, '0, "R2");
                step_a(1'(b % 2), 0, A_W'(1) << b, "R6");
                step_a(1, 0, '0, "R8");
            end
        end
    endtask

    task automatic t_inject_b;
        for (int s = 0; s < B_NS; s++) begin
            for (int b = 0; b < B_W; b++) begin
                step_b(0, 1, '0, "R10");
                for (int k = 0; k < s; k++) step_b(1, 0, '0, "R10");
                step_b(1'(b % 2), 0, B_W'(1) << b, "R10");
                step_b(1, 0, '0, "R10");
                step_b(1, 0, '0, "R10");
            end
        end
    endtask

    initial begin
        t_reset();
        t_count();
        t_hold();
        t_clear();
        t_inject_a();
        t_inject_b();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule